// File: doc/BRIEF.md
# Slow-Tick Seconds Counter with Time Alarm

This block is a memory-mapped timekeeping peripheral. A 47-bit counter advances by one on every pulse of a slow tick enable (nominally 32.768 kHz) while counting is enabled. The upper 32 bits therefore count whole seconds and the lower 15 bits count fractions of a second. A 32-bit alarm value is compared against the seconds field. A match raises a sticky alarm flag, and that flag drives an interrupt output and a wakeup output, each gated by its own enable.

Software reaches everything through a 32-bit register bus with word-aligned byte addresses. The control bits are captured at once but move into the slow domain through a short chain of stages that advance only on slow ticks. The readback, the counting and the output gating all follow the applied value, so software polls the control register until its write shows up. The counter can be loaded only while the applied enable is off. A spare 32-bit register holds the glitch-detect initialisation word that software writes during bring-up.

Top module: `lpsec_counter`

## Requirements
- R1: After reset these all read zero: the counter, the control readback, the status, the alarm register and the glitch-detect register. Both the interrupt and wakeup outputs are low.
- R2: Register byte offsets are: control 0x04, status 0x18, counter-high 0x1C, counter-low 0x20, alarm 0x24, glitch-detect 0x30. A read strobe returns its data on `bus_rdata` in the following cycle, and `bus_rdata` holds that value until the next read. A read of any other address, including a misaligned one (address bits 1:0 not zero), returns 0.
- R3: While counting is applied, each slow tick adds one to the 47-bit counter, and all ones wraps to zero. With no tick, the counter holds.
- R4: Counter-low carries counter bits 31:0. Counter-high carries counter bits 46:32 in its bits 14:0 and reads zero above them. Writes to either one load the counter only while the applied count enable is 0, and are ignored otherwise.
- R5: Control bit 0 is count enable, bit 1 is alarm enable and bit 3 is wakeup enable. All other control bits read back as 0.
- R6: A control write reaches the readback and takes effect on the third slow tick after the write. It does not take effect on fewer ticks, and never without ticks.
- R7: The alarm flag (status bit 0) is set in the cycle after the counting-enabled counter's bits 46:15 equal the alarm register. It stays set until a status write with bit 0 = 1 clears it. A set condition in the same cycle as a clear wins over the clear.
- R8: A status write with bit 0 = 0 leaves the alarm flag unchanged.
- R9: `alarm_irq` is high exactly while the alarm flag and the applied alarm enable are both 1. `wake_req` is high exactly while the alarm flag and the applied wakeup enable are both 1.
- R10: The glitch-detect register stores and returns any 32-bit value, for example 0x41736166.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle slow-clock tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| alarm_irq | output | 1 | Alarm interrupt request |
| wake_req | output | 1 | Wakeup request |

## Verification
The bench checks the control readback after two ticks and again after three. A design that applied control on the write cycle, or after the wrong number of ticks, would show the new value too early or too late. It loads the counter just below a seconds boundary and a second time at all ones. This exposes a seconds field taken from the wrong bit range, an alarm compared against the fractional bits, and a counter that fails to wrap. It writes the counter while counting and clears the flag while the match still holds. A design that let the load through, or let the clear win, would show a changed count or a dropped flag. It also enables the interrupt and the wakeup one at a time, so that crossed gating shows up as the wrong output rising.

// File: rtl/lpsec_pkg.sv
package lpsec_pkg;

    // Byte offsets of the registers inside the block.
    localparam logic [7:0] OFF_CTRL  = 8'h04;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_CNTHI = 8'h1C;
    localparam logic [7:0] OFF_CNTLO = 8'h20;
    localparam logic [7:0] OFF_ALARM = 8'h24;
    localparam logic [7:0] OFF_GUARD = 8'h30;

    // Control bit positions as software sees them.
    localparam int BIT_RUN   = 0;
    localparam int BIT_ALARM = 1;
    localparam int BIT_WAKE  = 3;

    typedef struct packed {
        logic wake;
        logic alarm;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/lpsec_sync.sv
module lpsec_sync
    import lpsec_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  ctrl_t req,
    output ctrl_t applied
);

    typedef struct packed {
        ctrl_t [STAGES-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.stg[0] = req;
            for (int i = 1; i < STAGES; i++) begin
                s_d.stg[i] = s_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign applied = s_q.stg[STAGES-1];

    // R6: the applied control never moves on a cycle without a slow tick
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(applied));

endmodule

// File: rtl/lpsec_count.sv
module lpsec_count #(
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15,
    localparam int SEC_W = CNT_W - FRAC_W,
    localparam int HI_W  = CNT_W - 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [31:0]      wdata,
    input  logic [SEC_W-1:0] alarm,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!run) begin
            if (ld_lo) c_d.cnt[31:0]      = wdata;
            if (ld_hi) c_d.cnt[CNT_W-1:32] = wdata[HI_W-1:0];
        end else if (tick) begin
            c_d.cnt = c_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt   = c_q.cnt;
    assign match = (c_q.cnt[CNT_W-1:FRAC_W] == alarm);

    // R3: one tick while running advances by exactly one (modulo the width)
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R4: bus writes cannot disturb a running counter
    p_no_load_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    // R3: a stopped counter with no load holds its value
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

endmodule

// File: rtl/lpsec_regs.sv
module lpsec_regs
    import lpsec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15,
    localparam int SEC_W = CNT_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  ctrl_t             applied,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              match,
    output ctrl_t             req,
    output logic [SEC_W-1:0]  alarm,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              irq,
    output logic              wake
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CNTHI = ADDR_W'(OFF_CNTHI);
    localparam logic [ADDR_W-1:0] A_CNTLO = ADDR_W'(OFF_CNTLO);
    localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFF_ALARM);
    localparam logic [ADDR_W-1:0] A_GUARD = ADDR_W'(OFF_GUARD);

    typedef struct packed {
        ctrl_t             req;
        logic [SEC_W-1:0]  alarm;
        logic [31:0]       guard;
        logic              flag;
        logic [31:0]       rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_ctrl, hit_stat, hit_hi, hit_lo, hit_alarm, hit_guard;
    logic clr, set_flag;
    logic [31:0] rd_mux;

    always_comb begin
        hit_ctrl  = (bus_addr == A_CTRL);
        hit_stat  = (bus_addr == A_STAT);
        hit_hi    = (bus_addr == A_CNTHI);
        hit_lo    = (bus_addr == A_CNTLO);
        hit_alarm = (bus_addr == A_ALARM);
        hit_guard = (bus_addr == A_GUARD);
    end

    assign clr      = bus_wr && hit_stat && bus_wdata[0];
    assign set_flag = applied.run && match;
    assign ld_lo    = bus_wr && hit_lo;
    assign ld_hi    = bus_wr && hit_hi;

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[BIT_RUN]   = applied.run;
            rd_mux[BIT_ALARM] = applied.alarm;
            rd_mux[BIT_WAKE]  = applied.wake;
        end
        if (hit_stat)  rd_mux[0] = r_q.flag;
        if (hit_hi)    rd_mux = 32'(cnt[CNT_W-1:32]);
        if (hit_lo)    rd_mux = cnt[31:0];
        if (hit_alarm) rd_mux = 32'(r_q.alarm);
        if (hit_guard) rd_mux = r_q.guard;
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr && hit_ctrl) begin
            r_d.req.run   = bus_wdata[BIT_RUN];
            r_d.req.alarm = bus_wdata[BIT_ALARM];
            r_d.req.wake  = bus_wdata[BIT_WAKE];
        end
        if (bus_wr && hit_alarm) r_d.alarm = bus_wdata[SEC_W-1:0];
        if (bus_wr && hit_guard) r_d.guard = bus_wdata;
        r_d.flag = (r_q.flag && !clr) || set_flag;
        if (bus_rd) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req       = r_q.req;
    assign alarm     = r_q.alarm;
    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.flag && applied.alarm;
    assign wake      = r_q.flag && applied.wake;

    // R7: the flag is sticky until a clearing status write
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !clr) |=> r_q.flag);

    // R7: a clear with no concurrent match drops the flag
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(applied.run && match)) |=> !r_q.flag);

    // R8: without a match the flag cannot appear
    p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.flag && !(applied.run && match)) |=> !r_q.flag);

    // R2: read data holds between read strobes
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/lpsec_counter.sv
module lpsec_counter
    import lpsec_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 47,
    parameter int FRAC_W     = 15,
    parameter int SYNC_TICKS = 3,
    localparam int SEC_W     = CNT_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq,
    output logic              wake_req
);

    ctrl_t             req, applied;
    logic [SEC_W-1:0]  alarm;
    logic [CNT_W-1:0]  cnt;
    logic              match, ld_lo, ld_hi;

    lpsec_sync #(.STAGES(SYNC_TICKS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .req     (req),
        .applied (applied)
    );

    lpsec_count #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick),
        .run   (applied.run),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .wdata (bus_wdata),
        .alarm (alarm),
        .cnt   (cnt),
        .match (match)
    );

    lpsec_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .applied   (applied),
        .cnt       (cnt),
        .match     (match),
        .req       (req),
        .alarm     (alarm),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .irq       (alarm_irq),
        .wake      (wake_req)
    );

    // R9: neither request can be high while its enable is off
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !applied.alarm |-> !alarm_irq);
    p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !applied.wake |-> !wake_req);

endmodule

// File: tb/sim_lpsec_counter.sv
`timescale 1ns/1ps
module sim_lpsec_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq, wake_req;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    lpsec_counter u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq), .wake_req(wake_req)
    );

    // Behavioural reference: bit0 run, bit1 alarm enable, bit2 wake enable
    logic [46:0] m_cnt;
    logic [2:0]  m_req;
    logic [2:0]  m_pipe [3];
    logic [31:0] m_alarm, m_guard, m_rdata;
    logic        m_flag;

    always @(posedge clk) begin
        logic [2:0]  app;
        logic [31:0] rv;
        if (!rst_n) begin
            m_cnt = '0; m_req = '0; m_alarm = '0; m_guard = '0;
            m_rdata = '0; m_flag = 1'b0;
            foreach (m_pipe[k]) m_pipe[k] = '0;
        end else begin
            app = m_pipe[2];
            rv = 32'h0;
            case (bus_addr)
                8'h04: rv = {28'h0, app[2], 1'b0, app[1], app[0]};
                8'h18: rv = {31'h0, m_flag};
                8'h1C: rv = {17'h0, m_cnt[46:32]};
                8'h20: rv = m_cnt[31:0];
                8'h24: rv = m_alarm;
                8'h30: rv = m_guard;
                default: rv = 32'h0;
            endcase
            if (bus_rd) m_rdata = rv;
            if (bus_wr && bus_addr == 8'h18 && bus_wdata[0]) m_flag = 1'b0;
            if (app[0] && m_cnt[46:15] == m_alarm) m_flag = 1'b1;
            if (!app[0]) begin
                if (bus_wr && bus_addr == 8'h20) m_cnt[31:0] = bus_wdata;
                if (bus_wr && bus_addr == 8'h1C) m_cnt[46:32] = bus_wdata[14:0];
            end else if (slow_tick) begin
                m_cnt = m_cnt + 47'd1;
            end
            if (slow_tick) begin
                m_pipe[2] = m_pipe[1];
                m_pipe[1] = m_pipe[0];
                m_pipe[0] = m_req;
            end
            if (bus_wr && bus_addr == 8'h04) m_req = {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
            if (bus_wr && bus_addr == 8'h24) m_alarm = bus_wdata;
            if (bus_wr && bus_addr == 8'h30) m_guard = bus_wdata;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (bus_rdata !== m_rdata || alarm_irq !== (m_flag & m_pipe[2][1]) ||
                wake_req !== (m_flag & m_pipe[2][2])) begin
                mismatched++;
                $display("FAIL %s model: rdata=%h irq=%b wake=%b expected rdata=%h irq=%b wake=%b",
                    phase, bus_rdata, alarm_irq, wake_req, m_rdata,
                    m_flag & m_pipe[2][1], m_flag & m_pipe[2][2]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; slow_tick = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; slow_tick = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic run(input int n, input logic t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = t;
        end
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        rd_expect(8'h04, 32'h0, "R1 ctrl");
        rd_expect(8'h18, 32'h0, "R1 status");
        rd_expect(8'h20, 32'h0, "R1 cnt lo");
        rd_expect(8'h1C, 32'h0, "R1 cnt hi");
        rd_expect(8'h24, 32'h0, "R1 alarm");
        rd_expect(8'h30, 32'h0, "R1 guard");
        chk("R1 irq", {31'h0, alarm_irq}, 32'h0);
        chk("R1 wake", {31'h0, wake_req}, 32'h0);

        phase = "R10";
        wr(8'h30, 32'h41736166);
        rd_expect(8'h30, 32'h41736166, "R10 guard");
        phase = "R2";
        rd_expect(8'h08, 32'h0, "R2 unmapped");
        rd_expect(8'h31, 32'h0, "R2 misaligned");

        phase = "R4";
        wr(8'h20, 32'h12345678);
        wr(8'h1C, 32'hFFFF8001);
        rd_expect(8'h1C, 32'h00000001, "R4 hi field");
        rd_expect(8'h20, 32'h12345678, "R4 lo load");

        phase = "R6";
        wr(8'h04, 32'h1);
        run(8, 1'b0);
        rd_expect(8'h04, 32'h0, "R6 no ticks");
        run(2, 1'b1);
        rd_expect(8'h04, 32'h0, "R6 two ticks");
        run(1, 1'b1);
        rd_expect(8'h04, 32'h1, "R6 third tick");

        phase = "R3";
        run(4, 1'b1);
        rd_expect(8'h20, 32'h1234567C, "R3 four ticks");
        run(5, 1'b0);
        rd_expect(8'h20, 32'h1234567C, "R3 hold no tick");
        phase = "R4";
        wr(8'h20, 32'h0);
        wr(8'h1C, 32'h7);
        rd_expect(8'h20, 32'h1234567C, "R4 lo ignored while running");
        rd_expect(8'h1C, 32'h00000001, "R4 hi ignored while running");

        phase = "R7";
        wr(8'h04, 32'h0);
        run(3, 1'b1);
        rd_expect(8'h04, 32'h0, "R6 disable applied");
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'h00017FFE);
        wr(8'h24, 32'h3);
        wr(8'h04, 32'h0B);
        run(3, 1'b1);
        rd_expect(8'h04, 32'h0B, "R5 ctrl readback");
        run(1, 1'b1);
        chk("R7 no early flag", {31'h0, alarm_irq}, 32'h0);
        run(1, 1'b1);
        @(negedge clk);
        chk("R9 irq on match", {31'h0, alarm_irq}, 32'h1);
        chk("R9 wake on match", {31'h0, wake_req}, 32'h1);
        rd_expect(8'h18, 32'h1, "R7 status set");
        wr(8'h18, 32'h1);
        rd_expect(8'h18, 32'h1, "R7 set beats clear");

        wr(8'h04, 32'h0A);
        run(3, 1'b1);
        phase = "R8";
        wr(8'h18, 32'h0);
        rd_expect(8'h18, 32'h1, "R8 zero write keeps flag");
        phase = "R7";
        wr(8'h18, 32'hFFFFFFFF);
        rd_expect(8'h18, 32'h0, "R7 clear all");
        chk("R9 irq low after clear", {31'h0, alarm_irq}, 32'h0);

        phase = "R9";
        wr(8'h04, 32'h09);
        run(3, 1'b1);
        @(negedge clk);
        chk("R9 wake only", {30'h0, alarm_irq, wake_req}, 32'h1);

        phase = "R3";
        wr(8'h04, 32'h0);
        run(3, 1'b1);
        wr(8'h18, 32'h1);
        wr(8'h1C, 32'h7FFF);
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h04, 32'h1);
        run(3, 1'b1);
        rd_expect(8'h1C, 32'h7FFF, "R3 at all ones");
        run(1, 1'b1);
        rd_expect(8'h20, 32'h0, "R3 wrap lo");
        rd_expect(8'h1C, 32'h0, "R3 wrap hi");

        phase = "R5";
        wr(8'h04, 32'hFFFFFFFF);
        run(3, 1'b1);
        rd_expect(8'h04, 32'h0000000B, "R5 reserved bits zero");

        run(4, 1'b0);
        finish_run();
    end

endmodule